// File: doc/BRIEF.md
# Data-strobe receive clock recovery and deserializer

This block sits behind a pair of serial receive lines that carry data-strobe encoded traffic. On every bit, exactly one of the two lines changes: data follows the bit value, and strobe toggles whenever data does not. The block recovers a receive clock as the XOR of the two lines and drives it out, so that each edge of the recovered clock marks one bit. The bit captured on a rising edge is the even bit. The bit captured on the following falling edge is the odd bit. The odd bit is re-registered, so that both bits of a pair change together on the rising edge of the recovered clock. Logic behind the block then works on pairs at half the serial bit rate.

An active-low reset forces the pair outputs to high impedance and clears the captured pair. After reset goes high, the block discards a guard window of recovered-clock edges before it presents received data. A local-loopback select replaces the received pair with the transmit-side parallel inputs. When the line pair is absent, both lines rest high, so the recovered clock stays low and the outputs hold.

Top module: `ds_rx_deser`

## Requirements
- R1: `rx_clk` equals `rx_data XOR rx_strobe` at all times.
- R2: The pair outputs change only on a rising edge of `rx_clk`. A falling edge leaves `rx_even` and `rx_odd` unchanged.
- R3: Outside the guard window, a rising edge of `rx_clk` puts two bits on the outputs. `rx_even` shows the bit taken at the previous rising edge. `rx_odd` shows the bit taken at the falling edge that followed it. The bit taken at any edge is the value of `rx_data` after that edge, so the pairs reproduce the serial stream in order.
- R4: After `rst_n` goes high, the first GUARD_EDGES (default 3) rising edges and their falling partners are discarded. Both outputs stay 0 until rising edge GUARD_EDGES+2. That edge presents the pair that starts at rising edge GUARD_EDGES+1.
- R5: While `rst_n` is low, `rx_drive` is 0 and `rx_even`/`rx_odd` are high impedance. A rising edge of `rx_clk` with `rst_n` low clears the captured pair to 0. `rx_drive` is 1 whenever `rst_n` is high.
- R6: With `rst_n` high and `loop_en` at 1, `rx_even` equals `tx_even` and `rx_odd` equals `tx_odd`. Clearing `loop_en` brings back the captured pair, which the loopback has not altered.
- R7: When both lines rest high and stop toggling, `rx_clk` is 0 and the pair outputs keep their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset; low gates the pair outputs to high impedance |
| rx_data | input | 1 | Serial data line |
| rx_strobe | input | 1 | Serial strobe line |
| loop_en | input | 1 | 1 selects the transmit-side pair onto the outputs |
| tx_even | input | 1 | Transmit-side even bit used in loopback |
| tx_odd | input | 1 | Transmit-side odd bit used in loopback |
| rx_even | output | 1 | Received even (rising-edge) bit |
| rx_odd | output | 1 | Received odd (falling-edge) bit |
| rx_drive | output | 1 | 1 while the pair outputs are driven |
| rx_clk | output | 1 | Recovered receive clock |

## Verification
Long runs of zeros and of ones make every edge come from the strobe line alone. An alternating run makes every edge come from the data line alone. Together they show that capture does not depend on which line moved. A fixed-seed random stream mixes both kinds of edge and checks the even/odd order pair by pair. Directed cases cover the guard window after each reset release (a second reset comes mid-stream), all four loopback input combinations and the restore afterwards, falling edges that must leave the outputs alone, and a move to the idle both-high state.

// File: rtl/ds_rx_pkg.sv
`timescale 1ns/1ps
package ds_rx_pkg;
  typedef struct packed {
    logic even;
    logic odd;
  } ds_pair_t;
endpackage

// File: rtl/ds_clk_recover.sv
`timescale 1ns/1ps
// Recovered clock: one line changes per bit, so each bit toggles the XOR once.
module ds_clk_recover (
  input  logic line_d,
  input  logic line_s,
  output logic rclk
);
  assign rclk = line_d ^ line_s;
endmodule

// File: rtl/ds_edge_capture.sv
`timescale 1ns/1ps
module ds_edge_capture
  import ds_rx_pkg::*;
#(
  parameter int GUARD_EDGES = 3
) (
  input  logic                                   rclk,
  input  logic                                   rst_n,
  input  logic                                   line_d,
  output logic [$clog2(GUARD_EDGES + 2) - 1 : 0] guard_cnt,
  output logic                                   even_q,
  output logic                                   odd_q,
  output ds_pair_t                               pair_q
);
  localparam int LAST  = GUARD_EDGES + 1;
  localparam int CNT_W = $clog2(GUARD_EDGES + 2);

  // Rising edge: take the even bit, advance the guard, publish the finished pair.
  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      guard_cnt <= '0;
      even_q    <= 1'b0;
      pair_q    <= '0;
    end else begin
      even_q <= line_d;
      if (guard_cnt != CNT_W'(LAST)) begin
        guard_cnt <= guard_cnt + 1'b1;
      end else begin
        pair_q.even <= even_q;
        pair_q.odd  <= odd_q;
      end
    end
  end

  // Falling edge: take the odd bit; it is re-registered at the next rise.
  always_ff @(negedge rclk) begin
    if (!rst_n) begin
      odd_q <= 1'b0;
    end else begin
      odd_q <= line_d;
    end
  end
endmodule

// File: rtl/ds_out_select.sv
`timescale 1ns/1ps
module ds_out_select
  import ds_rx_pkg::*;
(
  input  logic     rst_n,
  input  logic     loop_en,
  input  logic     tx_even,
  input  logic     tx_odd,
  input  ds_pair_t pair_q,
  output logic     rx_even,
  output logic     rx_odd,
  output logic     rx_drive
);
  ds_pair_t sel;

  always_comb begin
    if (loop_en) begin
      sel.even = tx_even;
      sel.odd  = tx_odd;
    end else begin
      sel = pair_q;
    end
  end

  assign rx_drive = rst_n;
  assign rx_even  = rst_n ? sel.even : 1'bz;
  assign rx_odd   = rst_n ? sel.odd  : 1'bz;
endmodule

// File: rtl/ds_rx_deser.sv
`timescale 1ns/1ps
module ds_rx_deser
  import ds_rx_pkg::*;
#(
  parameter int GUARD_EDGES = 3
) (
  input  logic rst_n,
  input  logic rx_data,
  input  logic rx_strobe,
  input  logic loop_en,
  input  logic tx_even,
  input  logic tx_odd,
  output logic rx_even,
  output logic rx_odd,
  output logic rx_drive,
  output logic rx_clk
);
  localparam int CNT_W = $clog2(GUARD_EDGES + 2);

  logic             rclk;
  logic [CNT_W-1:0] guard_cnt;
  logic             even_q;
  logic             odd_q;
  ds_pair_t         pair_q;

  ds_clk_recover u_rec (
    .line_d (rx_data),
    .line_s (rx_strobe),
    .rclk   (rclk)
  );

  ds_edge_capture #(.GUARD_EDGES(GUARD_EDGES)) u_cap (
    .rclk      (rclk),
    .rst_n     (rst_n),
    .line_d    (rx_data),
    .guard_cnt (guard_cnt),
    .even_q    (even_q),
    .odd_q     (odd_q),
    .pair_q    (pair_q)
  );

  ds_out_select u_sel (
    .rst_n    (rst_n),
    .loop_en  (loop_en),
    .tx_even  (tx_even),
    .tx_odd   (tx_odd),
    .pair_q   (pair_q),
    .rx_even  (rx_even),
    .rx_odd   (rx_odd),
    .rx_drive (rx_drive)
  );

  assign rx_clk = rclk;
endmodule

// File: rtl/ds_rx_deser_chk.sv
`timescale 1ns/1ps
module ds_rx_deser_chk
  import ds_rx_pkg::*;
#(
  parameter int GUARD_EDGES = 3
) (
  input logic                                   rx_clk,
  input logic                                   rst_n,
  input logic [$clog2(GUARD_EDGES + 2) - 1 : 0] guard_cnt,
  input logic                                   even_q,
  input logic                                   odd_q,
  input ds_pair_t                               pair_q
);
  localparam int CNT_W = $clog2(GUARD_EDGES + 2);

  // R4: inside the guard window nothing has been published
  a_r4_guard_quiet: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (guard_cnt <= CNT_W'(GUARD_EDGES)) |-> (pair_q == '0));

  // R4: the guard counter advances by one per rising edge until it is done
  a_r4_guard_steps: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (guard_cnt <= CNT_W'(GUARD_EDGES)) |=> (guard_cnt == CNT_W'($past(guard_cnt) + 1'b1)));

  // R3: after the guard, the published pair is the pair held at the previous rise
  a_r3_pair_source: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (guard_cnt == CNT_W'(GUARD_EDGES + 1)) |=>
      (pair_q.even == $past(even_q) && pair_q.odd == $past(odd_q)));

  // R5: a rising edge under reset clears the pair
  a_r5_reset_clears: assert property (@(posedge rx_clk)
    (!rst_n) |=> (pair_q == '0));
endmodule

bind ds_rx_deser ds_rx_deser_chk #(.GUARD_EDGES(GUARD_EDGES)) u_chk (
  .rx_clk    (rx_clk),
  .rst_n     (rst_n),
  .guard_cnt (guard_cnt),
  .even_q    (even_q),
  .odd_q     (odd_q),
  .pair_q    (pair_q)
);

// File: tb/ds_rx_deser_bench.sv
`timescale 1ns/1ps
module ds_rx_deser_bench;
  localparam int G = 3;

  logic clk = 1'b0;
  logic rst_n, d_line, s_line, loop_en, tx_even, tx_odd;
  logic rx_even, rx_odd, rx_drive, rx_clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int risen;
  logic ev, od, exp_e, exp_o;

  always #2 clk = ~clk;

  ds_rx_deser #(.GUARD_EDGES(G)) u_ds_rx_deser (
    .rst_n(rst_n), .rx_data(d_line), .rx_strobe(s_line), .loop_en(loop_en),
    .tx_even(tx_even), .tx_odd(tx_odd), .rx_even(rx_even), .rx_odd(rx_odd),
    .rx_drive(rx_drive), .rx_clk(rx_clk)
  );

  function automatic logic exp_clk(logic d, logic s);
    return d ^ s;
  endfunction

  function automatic bit guard_done(int n);
    return n >= G + 2;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Called after one line changed; the edge carries the data value.
  task automatic edge_event();
    logic b;
    #1;
    b = d_line;
    chk("R1 rx_clk", int'(rx_clk), int'(exp_clk(d_line, s_line)));
    if (exp_clk(d_line, s_line)) begin
      if (rst_n) begin
        risen++;
        if (guard_done(risen)) begin
          exp_e = ev;
          exp_o = od;
          chk("R3 even bit", int'(rx_even), int'(exp_e));
          chk("R3 odd bit", int'(rx_odd), int'(exp_o));
        end else begin
          exp_e = 1'b0;
          exp_o = 1'b0;
          chk("R4 guard even", int'(rx_even), 0);
          chk("R4 guard odd", int'(rx_odd), 0);
        end
      end else begin
        exp_e = 1'b0;
        exp_o = 1'b0;
        chk("R5 drive off", int'(rx_drive), 0);
      end
      ev = b;
    end else begin
      od = b;
      if (rst_n) begin
        chk("R2 even held on fall", int'(rx_even), int'(exp_e));
        chk("R2 odd held on fall", int'(rx_odd), int'(exp_o));
      end
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk);
    if (b != d_line) d_line = b;
    else s_line = ~s_line;
    edge_event();
  endtask

  task automatic do_reset(int nbits);
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R5 drive off in reset", int'(rx_drive), 0);
    for (int i = 0; i < nbits; i++) send_bit(1'($urandom_range(0, 1)));
    @(negedge clk);
    rst_n = 1'b1;
    risen = 0;
    exp_e = 1'b0;
    exp_o = 1'b0;
    #1;
    chk("R5 drive on", int'(rx_drive), 1);
    chk("R5 cleared even", int'(rx_even), 0);
    chk("R5 cleared odd", int'(rx_odd), 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; d_line = 1'b1; s_line = 1'b1;
    loop_en = 1'b0; tx_even = 1'b0; tx_odd = 1'b0;
    risen = 0; ev = 1'b0; od = 1'b0; exp_e = 1'b0; exp_o = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 drive off at start", int'(rx_drive), 0);
    chk("R7 idle clock low", int'(rx_clk), 0);
    do_reset(6);

    for (int i = 0; i < 24; i++) send_bit(1'b0);       // strobe-only edges
    for (int i = 0; i < 24; i++) send_bit(1'b1);       // strobe-only edges
    for (int i = 0; i < 24; i++) send_bit(1'(i & 1));  // data-only edges
    for (int i = 0; i < 200; i++) send_bit(1'($urandom_range(0, 1)));

    // R6 loopback with all input combinations, then restore
    @(negedge clk);
    loop_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tx_even = 1'(i >> 1);
      tx_odd  = 1'(i & 1);
      #1;
      chk("R6 loop even", int'(rx_even), int'(tx_even));
      chk("R6 loop odd", int'(rx_odd), int'(tx_odd));
      @(negedge clk);
    end
    loop_en = 1'b0;
    #1;
    chk("R6 restore even", int'(rx_even), int'(exp_e));
    chk("R6 restore odd", int'(rx_odd), int'(exp_o));

    // second reset in the middle of traffic, guard again
    do_reset(4);
    for (int i = 0; i < 40; i++) send_bit(1'($urandom_range(0, 1)));

    // move to idle both-high, one line at a time
    if (d_line != 1'b1) begin @(negedge clk); d_line = 1'b1; edge_event(); end
    if (s_line != 1'b1) begin @(negedge clk); s_line = 1'b1; edge_event(); end
    repeat (10) @(negedge clk);
    chk("R7 idle clock low", int'(rx_clk), 0);
    chk("R7 idle even held", int'(rx_even), int'(exp_e));
    chk("R7 idle odd held", int'(rx_odd), int'(exp_o));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule